// File: doc/BRIEF.md
# Dual 8-bit Reloading Interval Timer

This block holds two 8-bit timer channels. Each channel has a writable period value, a compare latch that holds the period in force, an up-counter, a sticky match flag and a toggle output. Each channel selects its count enable from seven prescaled internal enables that arrive as inputs, or from an external event pin. The event pin is synchronized and counted on its rising edges, so a channel can also work as an event counter. The period value is double-buffered. It moves into the compare latch only when the channel starts and at each match, so software can change the period while the timer runs without disturbing the period that is in progress.

Software drives the block through a small register bus. Writes are single-cycle and reads are combinational. The bus reaches a control register, a period register and a read-only count register for each channel. Setting the wide bit in channel 0's control register joins both channels into one 16-bit timer. In that mode channel 0 holds the low byte and channel 1 the high byte, and only channel 0's flag and toggle output respond to matches.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset every register, every count, both flags and both toggle outputs read 0.
- R2: A 3-bit source field picks the count enable. Values 0 to 6 pick tick_en[value] and value 7 picks the synchronized external event. A tick on a source that is not selected leaves the count unchanged.
- R3: A control write that sets the run bit while the channel is stopped clears the count to 0 and copies the period register into the compare latch. A control write that sets the run bit while the channel already runs changes neither.
- R4: While a channel runs, each selected tick advances the count by one. A tick that finds the count equal to the latch returns the count to 0 and reloads the latch. With period value n a match therefore happens every n+1 ticks, and counting goes on after each match.
- R5: The toggle output inverts at each match and changes at no other time.
- R6: A write to the period register while the channel runs takes effect only after the next match, so the current interval keeps its old length.
- R7: A match sets the flag. The flag stays set until a control write with bit 1 equal to 0 clears it. If a match and such a clear fall in the same cycle, the flag stays set. A control write with bit 1 equal to 1 leaves the flag unchanged.
- R8: A control write with the run bit at 0 stops the channel. While it is stopped, the count, flag and toggle output keep their values whatever ticks arrive, except for flag clears by R7.
- R9: The external input passes through two synchronizer flops. When ext_evt goes from low to high, the count of a channel that has selected the external event increments at the third rising clock edge, counting the first edge that samples ext_evt high.
- R10: With the wide bit (bit 5 of control 0) set, channel 0's run bit and source field drive a 16-bit count {count1,count0}. This count is compared with {latch1,latch0}, reloads both latches at a match, and sets only flag 0 and toggle output 0. Channel 1's own run bit, flag and toggle output have no effect and do not change from matches. A control 0 write that starts the channel and sets the wide bit in the same write also starts channel 1.
- R11: The register map is as follows. Address 0 and address 4 are the control registers of channel 0 and channel 1, with bit 0 run, bit 1 flag, bits 4:2 source and bit 5 wide (the wide bit is stored for channel 0 only). Address 1 and address 5 are the period registers. Address 2 and address 6 are the counts, which are read-only. Every other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 7 | Seven prescaled count enables, one cycle wide |
| ext_evt | input | 1 | Asynchronous external event input |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Combinational register read data |
| match_flag | output | 2 | Sticky match flag per channel |
| tog_out | output | 2 | Toggle output per channel |

## Verification
If a count or latch holds a wrong value, the toggle spacing drifts off n+1 ticks at the very next match, and the count register shows the error on the next read. If the flag logic is wrong, the flag port disagrees with the reference within one cycle of a match or clear. If synchronizer depth or edge detection is wrong, the count changes one edge too early or too late after an event, which a read in that cycle exposes. If the cascade is wrong, the wide period becomes shorter or longer than 259 ticks, or channel 1's toggle moves.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int SELW = 3;

    localparam logic [2:0] A_CTRL0 = 3'd0;
    localparam logic [2:0] A_DATA0 = 3'd1;
    localparam logic [2:0] A_CNT0  = 3'd2;
    localparam logic [2:0] A_CTRL1 = 3'd4;
    localparam logic [2:0] A_DATA1 = 3'd5;
    localparam logic [2:0] A_CNT1  = 3'd6;

    localparam int B_RUN  = 0;
    localparam int B_FLAG = 1;
    localparam int B_SEL  = 2;
    localparam int B_WIDE = 5;

    typedef struct packed {
        logic            wide;
        logic [SELW-1:0] sel;
        logic            run;
    } ctrl_t;
endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tmr_tick_mux.sv
module tmr_tick_mux #(
    parameter int NSRC = 7,
    parameter int SELW = 3
) (
    input  logic [NSRC-1:0] tick_en,
    input  logic            ext_rise,
    input  logic [SELW-1:0] sel,
    output logic            tick
);
    localparam int NSLOT = 2 ** SELW;
    logic [NSLOT-1:0] src;

    for (genvar i = 0; i < NSLOT; i++) begin : g_src
        if (i < NSRC) begin : g_int
            assign src[i] = tick_en[i];
        end else begin : g_ext
            assign src[i] = ext_rise;
        end
    end

    assign tick = src[sel];
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          adv,
    input  logic          wrap,
    input  logic          mark,
    input  logic          flag_clr,
    input  logic [DW-1:0] period,
    output logic [DW-1:0] cnt,
    output logic [DW-1:0] lat,
    output logic          flag,
    output logic          tog
);
    typedef struct packed {
        logic [DW-1:0] cnt;
        logic [DW-1:0] lat;
        logic          flag;
        logic          tog;
    } chan_t;

    chan_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start || wrap) begin
            st_d.cnt = '0;
            st_d.lat = period;
        end else if (adv) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (mark) begin
            st_d.flag = 1'b1;
            st_d.tog  = ~st_q.tog;
        end else if (flag_clr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt  = st_q.cnt;
    assign lat  = st_q.lat;
    assign flag = st_q.flag;
    assign tog  = st_q.tog;
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
    import tmr_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NSRC = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] tick_en,
    input  logic            ext_evt,
    input  logic            bus_we,
    input  logic [2:0]      bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic [1:0]      match_flag,
    output logic [1:0]      tog_out
);
    localparam int NCH = 2;

    typedef struct packed {
        ctrl_t [NCH-1:0]         ctrl;
        logic  [NCH-1:0][DW-1:0] data;
    } regs_t;

    regs_t regs_d, regs_q;

    logic                    ext_rise;
    logic [NCH-1:0]          tick, start, adv, wrap, mark, flag_clr;
    logic [NCH-1:0]          wr_ctrl, wr_data, step, eq;
    logic [NCH-1:0][DW-1:0]  cnt_w, lat_w;
    logic [NCH-1:0]          flag_w, tog_w;
    logic [NCH-1:0]          run_w;
    logic                    wide_w, start_wide, m16;
    logic [2:0]              ctrl_addr [NCH];
    logic [2:0]              data_addr [NCH];

    assign ctrl_addr[0] = A_CTRL0;
    assign ctrl_addr[1] = A_CTRL1;
    assign data_addr[0] = A_DATA0;
    assign data_addr[1] = A_DATA1;

    tmr_sync_edge #(.STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ext_evt),
        .rise (ext_rise)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        tmr_tick_mux #(.NSRC(NSRC), .SELW(SELW)) u_mux (
            .tick_en (tick_en),
            .ext_rise(ext_rise),
            .sel     (regs_q.ctrl[c].sel),
            .tick    (tick[c])
        );

        tmr_chan #(.DW(DW)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .start   (start[c]),
            .adv     (adv[c]),
            .wrap    (wrap[c]),
            .mark    (mark[c]),
            .flag_clr(flag_clr[c]),
            .period  (regs_q.data[c]),
            .cnt     (cnt_w[c]),
            .lat     (lat_w[c]),
            .flag    (flag_w[c]),
            .tog     (tog_w[c])
        );

        assign run_w[c] = regs_q.ctrl[c].run;
        assign eq[c]    = (cnt_w[c] == lat_w[c]);
    end

    assign wide_w = regs_q.ctrl[0].wide;

    // Bus decode, start detection and register next values
    always_comb begin
        regs_d = regs_q;
        for (int c = 0; c < NCH; c++) begin
            wr_ctrl[c]  = bus_we && (bus_addr == ctrl_addr[c]);
            wr_data[c]  = bus_we && (bus_addr == data_addr[c]);
            flag_clr[c] = wr_ctrl[c] && !bus_wdata[B_FLAG];
            if (wr_data[c]) regs_d.data[c] = bus_wdata;
            if (wr_ctrl[c]) begin
                regs_d.ctrl[c].run  = bus_wdata[B_RUN];
                regs_d.ctrl[c].sel  = bus_wdata[B_SEL +: SELW];
                regs_d.ctrl[c].wide = (c == 0) ? bus_wdata[B_WIDE] : 1'b0;
            end
        end
        start[0]   = wr_ctrl[0] && bus_wdata[B_RUN] && !regs_q.ctrl[0].run;
        start_wide = start[0] && bus_wdata[B_WIDE];
        start[1]   = start_wide ||
                     (wr_ctrl[1] && bus_wdata[B_RUN] && !regs_q.ctrl[1].run && !wide_w);
    end

    // Counting, match and cascade control
    always_comb begin
        step[0] = regs_q.ctrl[0].run && tick[0];
        step[1] = wide_w ? step[0] : (regs_q.ctrl[1].run && tick[1]);
        m16     = step[0] && eq[0] && eq[1];
        if (wide_w) begin
            mark[0] = m16;
            mark[1] = 1'b0;
            wrap    = {m16, m16};
            adv[0]  = step[0] && !m16;
            adv[1]  = step[0] && !m16 && (&cnt_w[0]);
        end else begin
            mark = step & eq;
            wrap = step & eq;
            adv  = step & ~eq;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    // Register readback
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL0, A_CTRL1: begin
                bus_rdata[B_RUN]          = regs_q.ctrl[bus_addr[2]].run;
                bus_rdata[B_FLAG]         = flag_w[bus_addr[2]];
                bus_rdata[B_SEL +: SELW]  = regs_q.ctrl[bus_addr[2]].sel;
                bus_rdata[B_WIDE]         = regs_q.ctrl[bus_addr[2]].wide;
            end
            A_DATA0, A_DATA1: bus_rdata = regs_q.data[bus_addr[2]];
            A_CNT0,  A_CNT1:  bus_rdata = cnt_w[bus_addr[2]];
            default:          bus_rdata = '0;
        endcase
    end

    assign match_flag = flag_w;
    assign tog_out    = tog_w;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_we,
    input logic [2:0]    bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic [1:0]    match_flag,
    input logic [1:0]    tog_out,
    input logic [1:0]    run_w,
    input logic          wide_w,
    input logic [DW-1:0] cnt0
);
    logic clr0;
    assign clr0 = bus_we && (bus_addr == 3'd0) && !bus_wdata[1];

    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (match_flag[0] && !clr0) |=> match_flag[0]);

    a_r5_toggle_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tog_out[0]) |-> match_flag[0]);

    a_r4_toggle_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tog_out[0]) |-> (cnt0 == '0));

    a_r8_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_w[0] && !bus_we) |=> ($stable(cnt0) && $stable(tog_out[0])));

    a_r3_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 3'd0 && bus_wdata[0] && !run_w[0]) |=> (cnt0 == '0));

    a_r10_wide_ch1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_w && !bus_we) |=> $stable(tog_out[1]));
endmodule

bind dual_interval_timer tmr_checker #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .match_flag(match_flag),
    .tog_out   (tog_out),
    .run_w     (run_w),
    .wide_w    (wide_w),
    .cnt0      (cnt_w[0])
);

// File: tb/tb_dual_interval_timer.sv
module tb_dual_interval_timer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] tick_en = '0;
    logic       ext_evt = 1'b0;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] match_flag, tog_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    dual_interval_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ext_evt(ext_evt),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .match_flag(match_flag), .tog_out(tog_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference state built from the requirements
    logic [7:0] m_cnt [2], m_lat [2], m_dat [2];
    logic [2:0] m_sel [2];
    logic [1:0] m_run, m_flag, m_tog;
    logic       m_wide, s1, s2, s3;

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_cnt[c] = 0; m_lat[c] = 0; m_dat[c] = 0; m_sel[c] = 0;
        end
        m_run = 0; m_flag = 0; m_tog = 0; m_wide = 0; s1 = 0; s2 = 0; s3 = 0;
    endtask

    task automatic model_step();
        logic rise, m16;
        logic [1:0] tk, wrc, strt, step, adv, wrap, mark, eq;
        rise = s2 & ~s3;
        for (int c = 0; c < 2; c++) begin
            tk[c]  = (m_sel[c] == 3'd7) ? rise : tick_en[m_sel[c]];
            wrc[c] = bus_we && (bus_addr == (c == 0 ? 3'd0 : 3'd4));
            eq[c]  = (m_cnt[c] == m_lat[c]);
        end
        strt[0] = wrc[0] && bus_wdata[0] && !m_run[0];
        strt[1] = (strt[0] && bus_wdata[5]) || (wrc[1] && bus_wdata[0] && !m_run[1] && !m_wide);
        step[0] = m_run[0] && tk[0];
        step[1] = m_wide ? step[0] : (m_run[1] && tk[1]);
        if (m_wide) begin
            m16 = step[0] && eq[0] && eq[1];
            mark = {1'b0, m16}; wrap = {m16, m16};
            adv[0] = step[0] && !m16;
            adv[1] = step[0] && !m16 && (m_cnt[0] == 8'hFF);
        end else begin
            mark = step & eq; wrap = step & eq; adv = step & ~eq;
        end
        for (int c = 0; c < 2; c++) begin
            if (strt[c] || wrap[c]) begin m_cnt[c] = 0; m_lat[c] = m_dat[c]; end
            else if (adv[c]) m_cnt[c] = m_cnt[c] + 8'd1;
            if (mark[c]) begin m_flag[c] = 1; m_tog[c] = ~m_tog[c]; end
            else if (wrc[c] && !bus_wdata[1]) m_flag[c] = 0;
            if (bus_we && bus_addr == (c == 0 ? 3'd1 : 3'd5)) m_dat[c] = bus_wdata;
            if (wrc[c]) begin
                m_run[c] = bus_wdata[0];
                m_sel[c] = bus_wdata[4:2];
                if (c == 0) m_wide = bus_wdata[5];
            end
        end
        s3 = s2; s2 = s1; s1 = ext_evt;
    endtask

    function automatic logic [7:0] model_read(logic [2:0] a);
        case (a)
            3'd0: return {2'b0, m_wide, m_sel[0], m_flag[0], m_run[0]};
            3'd4: return {2'b0, 1'b0, m_sel[1], m_flag[1], m_run[1]};
            3'd1: return m_dat[0];
            3'd5: return m_dat[1];
            3'd2: return m_cnt[0];
            3'd6: return m_cnt[1];
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock: model advances, outputs compared after the edge, write strobe dropped
    task automatic cyc();
        model_step();
        @(posedge clk);
        @(negedge clk);
        check("R7 flag", match_flag, m_flag);
        check("R5 toggle", tog_out, m_tog);
        bus_we = 1'b0;
    endtask

    task automatic chk_rd(logic [2:0] a, string tag);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, model_read(a));
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        cyc();
    endtask

    task automatic wait_tog(output int gap);
        logic t0;
        t0 = tog_out[0];
        gap = 0;
        while (tog_out[0] == t0 && gap < 2000) begin
            cyc();
            gap++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int gap;
        logic [7:0] held;
        model_reset();
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            bus_addr = 3'(a); #1;
            check("R1 reset reg", bus_rdata, 8'h00);
        end
        check("R1 reset outputs", {match_flag, tog_out}, 4'h0);

        // R4/R5 interval n+1 with every tick
        tick_en = 7'h7F;
        wr(3'd1, 8'd3);
        wr(3'd0, 8'h03);
        wait_tog(gap);
        wait_tog(gap);
        check("R4 interval n=3", gap, 4);
        wait_tog(gap);
        check("R5 toggle period half", gap, 4);

        // R6 period write mid-interval
        wr(3'd1, 8'd9);
        wait_tog(gap);
        check("R6 current period kept", gap, 3);
        wait_tog(gap);
        check("R6 new period used", gap, 10);

        // R7 flag write behaviour
        wr(3'd0, 8'h03);
        chk_rd(3'd0, "R7 flag kept by write of 1");
        check("R7 flag still set", match_flag[0], 1'b1);
        wr(3'd0, 8'h01);
        check("R7 flag cleared", match_flag[0], 1'b0);

        // R8 stop holds
        wr(3'd0, 8'h00);
        bus_addr = 3'd2; #1;
        held = bus_rdata;
        repeat (12) cyc();
        chk_rd(3'd2, "R8 count held");
        check("R8 count held direct", bus_rdata, held);

        // R3 start clears
        wr(3'd1, 8'hFF);
        wr(3'd0, 8'h01);
        chk_rd(3'd2, "R3 start count");
        check("R3 count zero", bus_rdata, 8'h00);
        repeat (5) cyc();
        wr(3'd0, 8'h01);
        chk_rd(3'd2, "R3 no restart while running");
        check("R3 count kept", bus_rdata, 8'd6);

        // R2 source select: sel=2
        wr(3'd0, 8'h00);
        wr(3'd0, 8'h09);
        tick_en = 7'b0000100;
        repeat (5) cyc();
        tick_en = 7'b1111011;
        repeat (5) cyc();
        chk_rd(3'd2, "R2 selected source");
        check("R2 count", bus_rdata, 8'd5);

        // R9 external event latency
        tick_en = 7'h00;
        wr(3'd0, 8'h00);
        wr(3'd0, 8'h1D);
        ext_evt = 1'b1;
        cyc(); cyc();
        chk_rd(3'd2, "R9 before third edge");
        check("R9 no early count", bus_rdata, 8'd0);
        cyc();
        chk_rd(3'd2, "R9 third edge");
        check("R9 counted once", bus_rdata, 8'd1);
        repeat (4) cyc();
        ext_evt = 1'b0;
        repeat (4) cyc();
        chk_rd(3'd2, "R9 high level counts once");

        // R10 wide mode: period 0x0102 -> 259 ticks
        wr(3'd0, 8'h00);
        tick_en = 7'h7F;
        wr(3'd1, 8'h02);
        wr(3'd5, 8'h01);
        wr(3'd0, 8'h21);
        wait_tog(gap);
        check("R10 wide first interval", gap, 259);
        wait_tog(gap);
        check("R10 wide interval", gap, 259);
        check("R10 ch1 flag quiet", match_flag[1], 1'b0);
        chk_rd(3'd6, "R10 high byte");
        wr(3'd0, 8'h00);

        // Random phase against the reference
        for (int i = 0; i < 6000; i++) begin
            tick_en = 7'($urandom);
            if ($urandom_range(3) == 0) ext_evt = ~ext_evt;
            if ($urandom_range(7) == 0) begin
                logic [2:0] a;
                logic [7:0] d;
                a = ($urandom_range(1) == 0) ? 3'd0 : 3'd4;
                if ($urandom_range(1) == 0) begin
                    a = a + 3'd1;
                    d = 8'($urandom_range(9));
                end else begin
                    d = {2'b00, ($urandom_range(5) == 0), 3'($urandom), 1'($urandom),
                         ($urandom_range(5) != 0)};
                end
                bus_we = 1'b1; bus_addr = a; bus_wdata = d;
            end
            cyc();
            case ($urandom_range(2))
                0: chk_rd(($urandom_range(1) == 0) ? 3'd2 : 3'd6, "R4 count readback");
                1: chk_rd(3'($urandom), "R11 register readback");
                default: chk_rd(($urandom_range(1) == 0) ? 3'd0 : 3'd4, "R10 control readback");
            endcase
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule